// File: doc/BRIEF.md
# GPIO Pin Interrupt Detector

This block watches up to 32 general-purpose pins and raises one interrupt line when a selected condition appears on an enabled, unmasked pin. Each pin has its own bits for three choices: edge or level sensing, which polarity counts as active, and whether it is enabled and masked. Every pin input passes through a two-flop synchroniser. A third flop keeps the previous synchronised value, and edges are found by comparing that value with the current one. An edge event stays latched until software writes a one to the matching bit of the clear register. A level source simply follows the synchronised pin.

The same register port also holds the plain output-data and output-enable registers that drive the pin pads, and a readback of the synchronised pin levels. Software reads the raw per-pin status (before enable and mask) and the masked status that feeds the interrupt line. The port is a simple single-cycle access: valid, write, byte address and data. Read data is combinational from the address.

Top module: `gpio_irq_unit`

## Requirements
- R1: After reset all configuration registers (output data, output enable, enable, mask, type, polarity) read 0, the masked status reads 0, `pin_oe` and `pin_out` are 0 and `irq` is 0.
- R2: The output-data register at offset 0x00 drives `pin_out` and the output-enable register at 0x04 drives `pin_oe` (bit 1 = output, 0 = input). Both take effect in the cycle after the write and read back as written.
- R3: The pin register at 0x24 returns the pin levels through a two-flop synchroniser. A change on `pin_in` becomes visible after the second rising clock edge.
- R4: With type bit 0 (type register 0x10) a pin is level-sensed. Its raw status bit (0x1C) equals the synchronised pin when its polarity bit (0x14) is 1, and the inverted pin when it is 0. It is not latched.
- R5: With type bit 1 a pin is edge-sensed. Polarity 1 selects rising edges and polarity 0 selects falling edges. The raw bit sets one cycle after the synchroniser output changes, and it stays set after the pin returns.
- R6: An edge is only captured while the pin's enable bit (0x08) is 1. Clearing the enable bit drops a pending edge one cycle after the write takes effect. Writing 0 to the enable register silences every source.
- R7: Writing ones to the clear register at 0x20 clears the matching latched edge bits and leaves the others alone. The clear register reads as 0.
- R8: An edge detected in the same cycle as a clear of its bit wins, and the bit stays latched.
- R9: The masked status at 0x18 equals raw AND enable AND NOT mask (mask register 0x0C). A mask bit of 1 hides that pin.
- R10: `irq` is 1 exactly when some masked status bit is 1, in the same cycle.
- R11: Writes to the masked status, raw status and pin registers change nothing.
- R12: Any other address, including a non-word-aligned one, reads 0, and writes to it change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_valid | input | 1 | Access strobe |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | AW (8) | Byte address |
| bus_wdata | input | DW (32) | Write data |
| bus_rdata | output | DW (32) | Read data for `bus_addr`, combinational |
| pin_in | input | NPINS (32) | Pin levels from the pads, asynchronous |
| pin_out | output | NPINS (32) | Output data to the pads |
| pin_oe | output | NPINS (32) | Per-pin output enable |
| irq | output | 1 | Aggregate interrupt |

## Verification
The assertions check the following on every cycle:
- A latched edge holds until cleared or disabled.
- A clear empties the latch unless a new edge arrives in the same cycle, and in that case the edge wins.
- A disabled pin never holds an edge.
- Writing 0 to the enable register silences `irq` on the next cycle.
- Writes to read-only registers leave the configuration untouched.
- An output-enable write lands as written.

Some behaviours can only be shown by the bench's scenarios against its reference model:
- The exact synchroniser latency on the pin readback.
- Level status following the pin in both polarities.
- Edges of the wrong polarity being ignored.
- No stale edge appearing after an enable is restored.
- Unmapped addresses reading zero.

// File: rtl/gpio_irq_pkg.sv
`timescale 1ns/1ps
package gpio_irq_pkg;
  // Byte offsets of the register window
  localparam int unsigned OFS_DOUT  = 'h00;
  localparam int unsigned OFS_OE    = 'h04;
  localparam int unsigned OFS_EN    = 'h08;
  localparam int unsigned OFS_MASK  = 'h0C;
  localparam int unsigned OFS_TYPE  = 'h10;
  localparam int unsigned OFS_POL   = 'h14;
  localparam int unsigned OFS_MSTAT = 'h18;
  localparam int unsigned OFS_RAW   = 'h1C;
  localparam int unsigned OFS_CLR   = 'h20;
  localparam int unsigned OFS_PIN   = 'h24;

  typedef enum logic [3:0] {
    SEL_DOUT, SEL_OE, SEL_EN, SEL_MASK, SEL_TYPE, SEL_POL,
    SEL_MSTAT, SEL_RAW, SEL_CLR, SEL_PIN, SEL_NONE
  } reg_sel_e;
endpackage

// File: rtl/gpio_sync.sv
`timescale 1ns/1ps
// Two-flop synchroniser plus one history stage for edge comparison
module gpio_sync #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] cur_o,
  output logic [W-1:0] prev_o
);
  logic [W-1:0] meta_q, cur_q, prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      cur_q  <= '0;
      prev_q <= '0;
    end else begin
      meta_q <= din;
      cur_q  <= meta_q;
      prev_q <= cur_q;
    end
  end

  assign cur_o  = cur_q;
  assign prev_o = prev_q;
endmodule

// File: rtl/gpio_irq_cell.sv
`timescale 1ns/1ps
// Per-pin edge latch and level qualification
module gpio_irq_cell (
  input  logic clk,
  input  logic rst_n,
  input  logic cur_i,
  input  logic prev_i,
  input  logic en_i,
  input  logic edge_mode_i,
  input  logic act_high_i,
  input  logic clr_i,
  output logic raw_o
);
  logic det, edge_d, edge_q;

  always_comb begin
    det    = act_high_i ? (cur_i & ~prev_i) : (~cur_i & prev_i);
    // a fresh edge overrides a clear of the same cycle
    edge_d = en_i & edge_mode_i & (det | (edge_q & ~clr_i));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) edge_q <= 1'b0;
    else        edge_q <= edge_d;
  end

  assign raw_o = edge_mode_i ? edge_q : (cur_i == act_high_i);

  a_r5_edge_held: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_q && en_i && edge_mode_i && !clr_i) |=> edge_q);
  a_r6_disabled_drops: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_i) |=> !edge_q);
  a_r7_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_q && clr_i && !det) |=> !edge_q);
  a_r8_edge_beats_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (det && clr_i && en_i && edge_mode_i) |=> edge_q);
endmodule

// File: rtl/gpio_irq_regs.sv
`timescale 1ns/1ps
// Register window: configuration storage, clear strobe and read mux
module gpio_irq_regs
  import gpio_irq_pkg::*;
#(
  parameter int NPINS = 32,
  parameter int DW    = 32,
  parameter int AW    = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_valid,
  input  logic             bus_write,
  input  logic [AW-1:0]    bus_addr,
  input  logic [DW-1:0]    bus_wdata,
  output logic [DW-1:0]    bus_rdata,
  input  logic [NPINS-1:0] raw_i,
  input  logic [NPINS-1:0] mstat_i,
  input  logic [NPINS-1:0] pin_i,
  output logic [NPINS-1:0] dout_o,
  output logic [NPINS-1:0] oe_o,
  output logic [NPINS-1:0] en_o,
  output logic [NPINS-1:0] msk_o,
  output logic [NPINS-1:0] typ_o,
  output logic [NPINS-1:0] pol_o,
  output logic [NPINS-1:0] clr_o
);
  reg_sel_e         sel;
  logic             wr_hit;
  logic             wr_dout, wr_oe, wr_en, wr_msk, wr_typ, wr_pol;
  logic [NPINS-1:0] wpins, rd_pins;
  logic [NPINS-1:0] dout_q, oe_q, en_q, msk_q, typ_q, pol_q;

  assign wpins  = bus_wdata[NPINS-1:0];
  assign wr_hit = bus_valid & bus_write;

  always_comb begin
    case (bus_addr)
      AW'(OFS_DOUT):  sel = SEL_DOUT;
      AW'(OFS_OE):    sel = SEL_OE;
      AW'(OFS_EN):    sel = SEL_EN;
      AW'(OFS_MASK):  sel = SEL_MASK;
      AW'(OFS_TYPE):  sel = SEL_TYPE;
      AW'(OFS_POL):   sel = SEL_POL;
      AW'(OFS_MSTAT): sel = SEL_MSTAT;
      AW'(OFS_RAW):   sel = SEL_RAW;
      AW'(OFS_CLR):   sel = SEL_CLR;
      AW'(OFS_PIN):   sel = SEL_PIN;
      default:        sel = SEL_NONE;
    endcase
  end

  // next-state: write enables and clear strobe
  always_comb begin
    wr_dout = wr_hit && (sel == SEL_DOUT);
    wr_oe   = wr_hit && (sel == SEL_OE);
    wr_en   = wr_hit && (sel == SEL_EN);
    wr_msk  = wr_hit && (sel == SEL_MASK);
    wr_typ  = wr_hit && (sel == SEL_TYPE);
    wr_pol  = wr_hit && (sel == SEL_POL);
    clr_o   = (wr_hit && (sel == SEL_CLR)) ? wpins : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dout_q <= '0;
      oe_q   <= '0;
      en_q   <= '0;
      msk_q  <= '0;
      typ_q  <= '0;
      pol_q  <= '0;
    end else begin
      if (wr_dout) dout_q <= wpins;
      if (wr_oe)   oe_q   <= wpins;
      if (wr_en)   en_q   <= wpins;
      if (wr_msk)  msk_q  <= wpins;
      if (wr_typ)  typ_q  <= wpins;
      if (wr_pol)  pol_q  <= wpins;
    end
  end

  always_comb begin
    case (sel)
      SEL_DOUT:  rd_pins = dout_q;
      SEL_OE:    rd_pins = oe_q;
      SEL_EN:    rd_pins = en_q;
      SEL_MASK:  rd_pins = msk_q;
      SEL_TYPE:  rd_pins = typ_q;
      SEL_POL:   rd_pins = pol_q;
      SEL_MSTAT: rd_pins = mstat_i;
      SEL_RAW:   rd_pins = raw_i;
      SEL_PIN:   rd_pins = pin_i;
      default:   rd_pins = '0;
    endcase
    bus_rdata = '0;
    bus_rdata[NPINS-1:0] = rd_pins;
  end

  assign dout_o = dout_q;
  assign oe_o   = oe_q;
  assign en_o   = en_q;
  assign msk_o  = msk_q;
  assign typ_o  = typ_q;
  assign pol_o  = pol_q;

  a_r2_oe_written: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && bus_write && bus_addr == AW'(OFS_OE)) |=> (oe_o == $past(bus_wdata[NPINS-1:0])));
  a_r11_readonly_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && bus_write && (bus_addr == AW'(OFS_MSTAT) || bus_addr == AW'(OFS_RAW) ||
     bus_addr == AW'(OFS_PIN))) |=> $stable({dout_o, oe_o, en_o, msk_o, typ_o, pol_o}));
endmodule

// File: rtl/gpio_irq_unit.sv
`timescale 1ns/1ps
module gpio_irq_unit #(
  parameter int NPINS = 32,
  parameter int DW    = 32,
  parameter int AW    = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_valid,
  input  logic             bus_write,
  input  logic [AW-1:0]    bus_addr,
  input  logic [DW-1:0]    bus_wdata,
  output logic [DW-1:0]    bus_rdata,
  input  logic [NPINS-1:0] pin_in,
  output logic [NPINS-1:0] pin_out,
  output logic [NPINS-1:0] pin_oe,
  output logic             irq
);
  import gpio_irq_pkg::*;

  logic [NPINS-1:0] cur, prev, raw, mstat;
  logic [NPINS-1:0] dout, oe, en, msk, typ, pol, clr;

  gpio_sync #(.W(NPINS)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .din    (pin_in),
    .cur_o  (cur),
    .prev_o (prev)
  );

  for (genvar i = 0; i < NPINS; i++) begin : g_pin
    gpio_irq_cell u_cell (
      .clk         (clk),
      .rst_n       (rst_n),
      .cur_i       (cur[i]),
      .prev_i      (prev[i]),
      .en_i        (en[i]),
      .edge_mode_i (typ[i]),
      .act_high_i  (pol[i]),
      .clr_i       (clr[i]),
      .raw_o       (raw[i])
    );
  end

  gpio_irq_regs #(.NPINS(NPINS), .DW(DW), .AW(AW)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_valid (bus_valid),
    .bus_write (bus_write),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .raw_i     (raw),
    .mstat_i   (mstat),
    .pin_i     (cur),
    .dout_o    (dout),
    .oe_o      (oe),
    .en_o      (en),
    .msk_o     (msk),
    .typ_o     (typ),
    .pol_o     (pol),
    .clr_o     (clr)
  );

  assign mstat   = raw & en & ~msk;
  assign irq     = |mstat;
  assign pin_out = dout;
  assign pin_oe  = oe;

  a_r10_irq_needs_live_pin: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> ((en & ~msk) != '0));
  a_r6_enable_zero_silences: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && bus_write && bus_addr == AW'(OFS_EN) && bus_wdata[NPINS-1:0] == '0) |=> !irq);
endmodule

// File: tb/tb_gpio_irq_unit.sv
`timescale 1ns/1ps
module tb_gpio_irq_unit;
  localparam logic [7:0] A_DOUT = 8'h00, A_OE = 8'h04, A_EN = 8'h08, A_MASK = 8'h0C,
                         A_TYPE = 8'h10, A_POL = 8'h14, A_MSTAT = 8'h18, A_RAW = 8'h1C,
                         A_CLR = 8'h20, A_PIN = 8'h24;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_valid = 1'b0, bus_write = 1'b0;
  logic [7:0]  bus_addr = 8'h00;
  logic [31:0] bus_wdata = '0, bus_rdata, pin_in = '0, pin_out, pin_oe;
  logic        irq;

  int n_chk = 0, n_fail = 0;
  bit cmp_on = 1'b0;

  gpio_irq_unit dut (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq)
  );

  always #5 clk = ~clk;

  // ---------------- behavioural reference model ----------------
  bit [31:0] m_dout, m_oe, m_en, m_msk, m_typ, m_pol, m_edge;
  bit [31:0] hist[$];   // [0]=previous, [1]=synchronised, [2]=first stage
  bit [31:0] t_s, t_p, t_det, t_clr;

  function automatic bit [31:0] m_raw();
    return (m_typ & m_edge) | (~m_typ & ~(hist[1] ^ m_pol));
  endfunction

  function automatic bit [31:0] m_read(input logic [7:0] a);
    case (a)
      A_DOUT:  return m_dout;
      A_OE:    return m_oe;
      A_EN:    return m_en;
      A_MASK:  return m_msk;
      A_TYPE:  return m_typ;
      A_POL:   return m_pol;
      A_MSTAT: return m_raw() & m_en & ~m_msk;
      A_RAW:   return m_raw();
      A_PIN:   return hist[1];
      default: return 32'h0;
    endcase
  endfunction

  function automatic string tag_of(input logic [7:0] a);
    case (a)
      A_DOUT, A_OE:          return "R2";
      A_PIN:                 return "R3";
      A_TYPE, A_POL, A_RAW:  return "R4";
      A_EN:                  return "R6";
      A_CLR:                 return "R7";
      A_MASK, A_MSTAT:       return "R9";
      default:               return "R12";
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_dout = 0; m_oe = 0; m_en = 0; m_msk = 0; m_typ = 0; m_pol = 0; m_edge = 0;
      hist = '{32'h0, 32'h0, 32'h0};
    end else begin
      t_s   = hist[1];
      t_p   = hist[0];
      t_det = (m_pol & t_s & ~t_p) | (~m_pol & ~t_s & t_p);
      t_clr = (bus_valid && bus_write && bus_addr == A_CLR) ? bus_wdata : 32'h0;
      m_edge = m_en & m_typ & (t_det | (m_edge & ~t_clr));
      if (bus_valid && bus_write) begin
        case (bus_addr)
          A_DOUT: m_dout = bus_wdata;
          A_OE:   m_oe   = bus_wdata;
          A_EN:   m_en   = bus_wdata;
          A_MASK: m_msk  = bus_wdata;
          A_TYPE: m_typ  = bus_wdata;
          A_POL:  m_pol  = bus_wdata;
          default: ;
        endcase
      end
      hist.push_back(pin_in);
      void'(hist.pop_front());
    end
  end

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h at %0t", tag, got, exp, $time);
    end
  endtask

  // per-cycle comparison against the model, away from the rising edge
  always @(negedge clk) begin
    if (cmp_on) begin
      chk(tag_of(bus_addr), bus_rdata, m_read(bus_addr));
      chk("R10", {31'b0, irq}, {31'b0, |(m_raw() & m_en & ~m_msk)});
      chk("R2", pin_out, m_dout);
      chk("R2", pin_oe, m_oe);
    end
  end

  // ---------------- stimulus helpers (called 2 ns after a rising edge) ----------------
  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
    tick(1);
    bus_valid = 1'b0; bus_write = 1'b0;
  endtask

  task automatic rd(input string tag, input logic [7:0] a, input logic [31:0] msk,
                    input logic [31:0] exp);
    bus_addr = a;
    #4;
    chk(tag, bus_rdata & msk, exp);
  endtask

  task automatic irq_is(input string tag, input logic e);
    chk(tag, {31'b0, irq}, {31'b0, e});
  endtask

  initial begin
    #2_000_000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    tick(3);
    rst_n = 1'b1;
    cmp_on = 1'b1;
    tick(1);

    // R1 reset state
    rd("R1", A_DOUT, '1, 0);  rd("R1", A_OE, '1, 0);   rd("R1", A_EN, '1, 0);
    rd("R1", A_MASK, '1, 0);  rd("R1", A_TYPE, '1, 0); rd("R1", A_POL, '1, 0);
    rd("R1", A_MSTAT, '1, 0);
    chk("R1", pin_oe, 0); irq_is("R1", 1'b0);
    tick(1);

    // R2 output data / direction
    wr(A_DOUT, 32'hA5A5_0F0F);
    wr(A_OE, 32'hFFFF_0000);
    chk("R2", pin_out, 32'hA5A5_0F0F); chk("R2", pin_oe, 32'hFFFF_0000);
    rd("R2", A_OE, '1, 32'hFFFF_0000);
    tick(1);

    // R3 synchroniser latency
    pin_in = 32'h1234_5678;
    tick(1); rd("R3", A_PIN, '1, 32'h0);
    tick(1); rd("R3", A_PIN, '1, 32'h1234_5678);

    // R4 level sensing, both polarities
    pin_in = 0; tick(3);
    wr(A_EN, 32'h3); wr(A_POL, 32'h1);
    rd("R4", A_RAW, '1, 32'hFFFF_FFFE);
    rd("R9", A_MSTAT, '1, 32'h2); irq_is("R10", 1'b1);
    tick(1);
    pin_in = 32'h3;
    tick(1); rd("R4", A_RAW, '1, 32'hFFFF_FFFE);
    tick(1); rd("R4", A_RAW, '1, 32'hFFFF_FFFD);
    rd("R9", A_MSTAT, '1, 32'h1);
    tick(1);
    pin_in = 32'h0; tick(2);
    rd("R4", A_RAW, 32'h3, 32'h2);

    // R9 masking
    pin_in = 32'h1; tick(2);
    rd("R9", A_MSTAT, '1, 32'h3);
    tick(1);
    wr(A_MASK, 32'h2);
    rd("R9", A_MSTAT, '1, 32'h1); irq_is("R10", 1'b1);
    tick(1);
    wr(A_MASK, 32'h3);
    rd("R9", A_MSTAT, '1, 32'h0); irq_is("R9", 1'b0);
    rd("R9", A_RAW, 32'h3, 32'h3);
    tick(1);
    wr(A_MASK, 32'h0);

    // R5 edge sensing: bit4 rising, bit5 falling
    wr(A_EN, 32'h0);
    pin_in = 32'h0; tick(3);
    wr(A_TYPE, 32'h30); wr(A_POL, 32'h10); wr(A_EN, 32'h30);
    pin_in = 32'h20; tick(4);
    rd("R5", A_RAW, 32'h30, 32'h0); irq_is("R5", 1'b0);
    tick(1);
    pin_in = 32'h30;
    tick(2); rd("R5", A_RAW, 32'h30, 32'h0);
    tick(1); rd("R5", A_RAW, 32'h30, 32'h10); irq_is("R10", 1'b1);
    tick(1);
    pin_in = 32'h10; tick(3);
    rd("R5", A_RAW, 32'h30, 32'h30);
    tick(1);
    pin_in = 32'h0; tick(3);
    rd("R5", A_RAW, 32'h30, 32'h30);
    tick(1);

    // R7 write-one clear
    wr(A_CLR, 32'h10);
    rd("R7", A_RAW, 32'h30, 32'h20);
    rd("R7", A_CLR, '1, 32'h0);
    tick(1);
    wr(A_CLR, 32'h20);
    rd("R7", A_RAW, 32'h30, 32'h0); irq_is("R7", 1'b0);
    tick(1);

    // R8 edge in the same cycle as its clear
    pin_in = 32'h10; tick(3);
    rd("R8", A_RAW, 32'h10, 32'h10);
    tick(1);
    pin_in = 32'h0; tick(3);
    pin_in = 32'h10;
    tick(2);
    wr(A_CLR, 32'h10);
    rd("R8", A_RAW, 32'h10, 32'h10);
    tick(1);
    wr(A_CLR, 32'h10);
    rd("R7", A_RAW, 32'h10, 32'h0);
    tick(1);

    // R6 enable gating
    pin_in = 32'h0; tick(3);
    pin_in = 32'h10; tick(3);
    rd("R6", A_RAW, 32'h10, 32'h10);
    tick(1);
    wr(A_EN, 32'h0);
    tick(1);
    rd("R6", A_RAW, 32'h10, 32'h0); irq_is("R6", 1'b0);
    tick(1);
    pin_in = 32'h0; tick(3);
    pin_in = 32'h10; tick(3);
    rd("R6", A_RAW, 32'h10, 32'h0);
    tick(1);
    wr(A_EN, 32'h30);
    tick(1);
    rd("R6", A_RAW, 32'h30, 32'h0); irq_is("R6", 1'b0);
    tick(1);

    // R11 read-only registers
    wr(A_RAW, 32'hFFFF_FFFF); wr(A_MSTAT, 32'hFFFF_FFFF); wr(A_PIN, 32'hFFFF_FFFF);
    rd("R11", A_DOUT, '1, 32'hA5A5_0F0F);
    rd("R11", A_EN, '1, 32'h30);
    rd("R11", A_PIN, '1, 32'h10);
    rd("R11", A_RAW, 32'h30, 32'h0);
    tick(1);

    // R12 unmapped addresses
    rd("R12", 8'h80, '1, 32'h0);
    rd("R12", 8'h02, '1, 32'h0);
    tick(1);
    wr(8'h80, 32'hFFFF_FFFF); wr(8'h01, 32'hFFFF_FFFF);
    rd("R12", A_DOUT, '1, 32'hA5A5_0F0F);
    rd("R12", A_OE, '1, 32'hFFFF_0000);
    tick(2);

    cmp_on = 1'b0;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule